// File: doc/BRIEF.md
# OLED Window Addressing Command Generator

This block turns a window request (x start, width, first page, page count) into the command bytes that a page-organised monochrome OLED controller needs before it accepts pixel data for that window. It then passes the window's pixel bytes through from a separate pixel input, so that commands and data leave on a single byte stream. Each byte on that stream carries a command/data flag and moves under a valid/ready handshake. Serial transport is handled further downstream.

Two addressing styles are supported. In horizontal style the block sends a column range command and a page range command, followed by all of the window's data in one run. It remembers the last column range and the last page range it programmed, and it skips a range command when the new range matches the remembered one. In page style the block positions the controller at the start of every page with a three-byte sequence, followed by that page's data bytes. A strap input forces page style for controllers that support nothing else. Column and page offsets are added to the window before any byte is formed.

FSM states: `S_IDLE`, `S_COL_OP`, `S_COL_BEG`, `S_COL_END`, `S_PG_OP`, `S_PG_BEG`, `S_PG_END`, `S_POS_PAGE`, `S_POS_CLO`, `S_POS_CHI`, `S_DATA`. Transitions:

- In horizontal style, `S_IDLE` moves on an accepted request to `S_COL_OP`. It goes to `S_PG_OP` instead if the column range is cached, and to `S_DATA` if both ranges are cached.
- In page style, `S_IDLE` moves on an accepted request to `S_POS_PAGE`.
- The column chain runs `S_COL_OP`→`S_COL_BEG`→`S_COL_END`. From there it goes to `S_PG_OP`, or to `S_DATA` when the page range is cached.
- The page chain runs `S_PG_OP`→`S_PG_BEG`→`S_PG_END`→`S_DATA`.
- The positioning chain runs `S_POS_PAGE`→`S_POS_CLO`→`S_POS_CHI`→`S_DATA`.
- `S_DATA` returns to `S_IDLE` after the window's last byte. In page style it goes to `S_POS_PAGE` after the last byte of each page that is not the final page.
- Every step out of a command state happens on an accepted byte.

Top module: `win_cmd_gen`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle, and a request raised while busy is ignored.
- R2: In horizontal style, a column range command is the three command bytes 0x21, start column, end column, where end = start + width − 1 (mod 256).
- R3: In horizontal style, a page range command is the three command bytes 0x22, start page, end page, where end = start + pages − 1 (mod 256). When both range commands are sent, the column range comes first.
- R4: A range command is omitted when its start and end both equal the last programmed values for that range. The column range and the page range are judged independently of each other.
- R5: The first horizontal request after reset emits both range commands, whatever the window.
- R6: In page style, each page is positioned with three command bytes in this order: 0xB0 OR (page number bits [2:0]), then the column start bits [3:0], then 0x10 OR the column start bits [7:4].
- R7: In page style, one positioning triplet precedes each page, and that page's width data bytes follow it directly. In horizontal style, all width × pages data bytes follow the range setup in one run. Data bytes are the `pix_byte` values in arrival order, with `out_is_cmd` = 0. Command bytes carry `out_is_cmd` = 1.
- R8: `page_only` = 1 selects page style regardless of `mode_page`. Page-style requests leave the remembered ranges untouched.
- R9: `done` pulses high for exactly one cycle after the window's last data byte is accepted, and the block is idle in that cycle.
- R10: A command byte presented while `out_ready` is low stays valid and unchanged until it is accepted.
- R11: The column start is `col_off` + `req_x` and the page start is `page_off` + `req_page`, both mod 256.
- R12: `pix_ready` is high only during the data phase and only when `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Window request |
| req_ready | output | 1 | High while idle; request taken when both high |
| req_x | input | 8 | Window x start |
| req_width | input | 8 | Window width in columns (1..255) |
| req_page | input | 8 | First page of window |
| req_pages | input | 8 | Number of pages (1..255) |
| col_off | input | 8 | Column offset added to x start |
| page_off | input | 8 | Page offset added to first page |
| mode_page | input | 1 | 1 selects page style, 0 horizontal |
| page_only | input | 1 | Variant strap forcing page style |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_byte | output | 8 | Output byte |
| out_is_cmd | output | 1 | 1 for command byte, 0 for data byte |
| pix_valid | input | 1 | Pixel byte available |
| pix_ready | output | 1 | Pixel byte consumed |
| pix_byte | input | 8 | Pixel data byte |
| done | output | 1 | One-cycle pulse at end of window |

## Verification
Every window shape in a small grid is issued twice in a row. The first issue shows whether a changed range is reprogrammed, and the repeat shows whether the cached range is skipped. Sweeping the page count while the width is held apart from it separates the page range check from the column range check.

The same grid is run in horizontal style, in page style chosen by `mode_page`, and in page style forced by `page_only`. Because page-style runs are interleaved with horizontal runs, a page-style run that corrupted the range cache would show up in the next horizontal stream. An offset that wraps past 255 exposes missing modulo arithmetic. A request held high during a busy transfer shows whether it is wrongly taken.

Downstream and pixel stalls are imposed on independent periodic patterns. Under these stalls a lost, repeated or reordered byte changes the recorded stream.

// File: rtl/win_cmd_pkg.sv
package win_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_COL_RANGE  = 8'h21;
    localparam logic [7:0] OP_PAGE_RANGE = 8'h22;
    localparam logic [7:0] OP_PAGE_POS   = 8'hB0;
    localparam logic [7:0] OP_COL_LO     = 8'h00;
    localparam logic [7:0] OP_COL_HI     = 8'h10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_COL_OP,
        S_COL_BEG,
        S_COL_END,
        S_PG_OP,
        S_PG_BEG,
        S_PG_END,
        S_POS_PAGE,
        S_POS_CLO,
        S_POS_CHI,
        S_DATA
    } win_state_e;

endpackage

// File: rtl/win_range_cache.sv
module win_range_cache #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_beg,
    input  logic [W-1:0] wr_end,
    input  logic [W-1:0] cmp_beg,
    input  logic [W-1:0] cmp_end,
    output logic         hit
);

    logic         vld_q;
    logic [W-1:0] beg_q;
    logic [W-1:0] end_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            beg_q <= '0;
            end_q <= '0;
        end else if (wr) begin
            vld_q <= 1'b1;
            beg_q <= wr_beg;
            end_q <= wr_end;
        end
    end

    assign hit = vld_q && (beg_q == cmp_beg) && (end_q == cmp_end);

endmodule

// File: rtl/win_beat_cnt.sv
module win_beat_cnt #(
    parameter int CW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] span_m1,
    input  logic [PW-1:0] pages_m1,
    output logic          last_beat,
    output logic          last_page,
    output logic [PW-1:0] page_idx
);

    logic [CW-1:0] col_q;
    logic [PW-1:0] pg_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col_q <= '0;
            pg_q  <= '0;
        end else if (step) begin
            if (last_beat) begin
                col_q <= '0;
                pg_q  <= pg_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    assign last_beat = (col_q == span_m1);
    assign last_page = (pg_q == pages_m1);
    assign page_idx  = pg_q;

endmodule

// File: rtl/win_cmd_gen.sv
module win_cmd_gen
    import win_cmd_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int PG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [COL_W-1:0] req_x,
    input  logic [COL_W-1:0] req_width,
    input  logic [PG_W-1:0]  req_page,
    input  logic [PG_W-1:0]  req_pages,
    input  logic [COL_W-1:0] col_off,
    input  logic [PG_W-1:0]  page_off,
    input  logic             mode_page,
    input  logic             page_only,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_is_cmd,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [7:0]       pix_byte,
    output logic             done
);

    localparam int PN_W = 3;

    win_state_e state_q, state_d;

    logic [COL_W-1:0] cbeg_q, cend_q, span_m1_q;
    logic [PG_W-1:0]  pbeg_q, pend_q, pages_m1_q;
    logic             paged_q, need_pg_q, done_q;

    logic [COL_W-1:0] in_cbeg, in_cend;
    logic [PG_W-1:0]  in_pbeg, in_pend;
    logic             in_paged;
    logic             col_hit, pg_hit;
    logic             accept, fire;
    logic             last_beat, last_page;
    logic [PG_W-1:0]  page_idx, page_num;

    assign in_cbeg  = col_off + req_x;
    assign in_cend  = in_cbeg + req_width - 1'b1;
    assign in_pbeg  = page_off + req_page;
    assign in_pend  = in_pbeg + req_pages - 1'b1;
    assign in_paged = mode_page | page_only;

    assign accept = req_valid && (state_q == S_IDLE);
    assign fire   = out_valid && out_ready;

    win_range_cache #(.W(COL_W)) u_col_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      ((state_q == S_COL_END) && fire),
        .wr_beg  (cbeg_q),
        .wr_end  (cend_q),
        .cmp_beg (in_cbeg),
        .cmp_end (in_cend),
        .hit     (col_hit)
    );

    win_range_cache #(.W(PG_W)) u_pg_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      ((state_q == S_PG_END) && fire),
        .wr_beg  (pbeg_q),
        .wr_end  (pend_q),
        .cmp_beg (in_pbeg),
        .cmp_end (in_pend),
        .hit     (pg_hit)
    );

    win_beat_cnt #(.CW(COL_W), .PW(PG_W)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .step      ((state_q == S_DATA) && fire),
        .span_m1   (span_m1_q),
        .pages_m1  (pages_m1_q),
        .last_beat (last_beat),
        .last_page (last_page),
        .page_idx  (page_idx)
    );

    assign page_num = pbeg_q + page_idx;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (in_paged)      state_d = S_POS_PAGE;
                    else if (!col_hit) state_d = S_COL_OP;
                    else if (!pg_hit)  state_d = S_PG_OP;
                    else               state_d = S_DATA;
                end
            end
            S_COL_OP:   if (fire) state_d = S_COL_BEG;
            S_COL_BEG:  if (fire) state_d = S_COL_END;
            S_COL_END:  if (fire) state_d = need_pg_q ? S_PG_OP : S_DATA;
            S_PG_OP:    if (fire) state_d = S_PG_BEG;
            S_PG_BEG:   if (fire) state_d = S_PG_END;
            S_PG_END:   if (fire) state_d = S_DATA;
            S_POS_PAGE: if (fire) state_d = S_POS_CLO;
            S_POS_CLO:  if (fire) state_d = S_POS_CHI;
            S_POS_CHI:  if (fire) state_d = S_DATA;
            S_DATA: begin
                if (fire && last_beat) begin
                    if (last_page)    state_d = S_IDLE;
                    else if (paged_q) state_d = S_POS_PAGE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cbeg_q     <= '0;
            cend_q     <= '0;
            pbeg_q     <= '0;
            pend_q     <= '0;
            span_m1_q  <= '0;
            pages_m1_q <= '0;
            paged_q    <= 1'b0;
            need_pg_q  <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_DATA) && fire && last_beat && last_page;
            if (accept) begin
                cbeg_q     <= in_cbeg;
                cend_q     <= in_cend;
                pbeg_q     <= in_pbeg;
                pend_q     <= in_pend;
                span_m1_q  <= req_width - 1'b1;
                pages_m1_q <= req_pages - 1'b1;
                paged_q    <= in_paged;
                need_pg_q  <= !pg_hit;
            end
        end
    end

    // output logic
    always_comb begin
        out_valid  = 1'b1;
        out_is_cmd = 1'b1;
        out_byte   = 8'h00;
        pix_ready  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                out_valid  = 1'b0;
                out_is_cmd = 1'b0;
            end
            S_COL_OP:   out_byte = OP_COL_RANGE;
            S_COL_BEG:  out_byte = 8'(cbeg_q);
            S_COL_END:  out_byte = 8'(cend_q);
            S_PG_OP:    out_byte = OP_PAGE_RANGE;
            S_PG_BEG:   out_byte = 8'(pbeg_q);
            S_PG_END:   out_byte = 8'(pend_q);
            S_POS_PAGE: out_byte = OP_PAGE_POS | 8'(page_num[PN_W-1:0]);
            S_POS_CLO:  out_byte = OP_COL_LO | 8'(cbeg_q[3:0]);
            S_POS_CHI:  out_byte = OP_COL_HI | 8'(4'(cbeg_q >> 4));
            S_DATA: begin
                out_valid  = pix_valid;
                out_is_cmd = 1'b0;
                out_byte   = pix_byte;
                pix_ready  = out_ready;
            end
            default: out_valid = 1'b0;
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign done      = done_q;

endmodule

// File: rtl/win_cmd_gen_chk.sv
module win_cmd_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_is_cmd,
    input logic       pix_ready,
    input logic       done
);

    // R1: once a request is taken the block is busy on the next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9: done coincides with idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: stalled command byte held
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && out_is_cmd |=> out_valid && out_is_cmd && $stable(out_byte));

    // R12: pixel consumption only in data phase with downstream ready
    a_r12_pix_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> out_ready && !out_is_cmd && !req_ready);

endmodule

bind win_cmd_gen win_cmd_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .out_is_cmd (out_is_cmd),
    .pix_ready  (pix_ready),
    .done       (done)
);

// File: tb/win_cmd_gen_bench.sv
module win_cmd_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_x = '0, req_width = 8'd1, req_page = '0, req_pages = 8'd1;
    logic [7:0] col_off = '0, page_off = '0;
    logic       mode_page = 1'b0, page_only = 1'b0;
    logic       out_valid, out_ready, out_is_cmd;
    logic [7:0] out_byte;
    logic       pix_valid, pix_ready;
    logic [7:0] pix_byte;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int done_cnt = 0;

    logic [8:0] got_q[$];
    logic [8:0] exp_q[$];

    // bench model state
    bit         m_cv = 0, m_pv = 0;
    logic [7:0] m_cb, m_ce, m_pb, m_pe;
    logic [7:0] m_dat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_cmd_gen u_win_cmd_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_width(req_width), .req_page(req_page), .req_pages(req_pages),
        .col_off(col_off), .page_off(page_off), .mode_page(mode_page), .page_only(page_only),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_is_cmd(out_is_cmd), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_byte(pix_byte), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // downstream / pixel source driver and stream recorder
    initial begin
        bit pend;
        pend = 0;
        out_ready = 1'b0;
        pix_valid = 1'b0;
        pix_byte  = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend) pix_byte = pix_byte + 1'b1;
            out_ready = (cyc % 3) != 2;
            pix_valid = (cyc % 5) != 4;
            #1;
            pend = 0;
            if (rst_n) begin
                if (out_valid && out_ready) begin
                    got_q.push_back({out_is_cmd, out_byte});
                    pend = !out_is_cmd;
                end
                if (done) done_cnt++;
            end
        end
    end

    // watchdog
    initial begin
        wait (cyc > WATCHDOG);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // expected stream for one request
    task automatic model(input logic [7:0] x, w, fp, p, co, po, input bit paged);
        logic [7:0] cb, ce, pb, pe, pn;
        cb = co + x;
        ce = cb + w - 8'd1;
        pb = po + fp;
        pe = pb + p - 8'd1;
        if (paged) begin
            for (int i = 0; i < p; i++) begin
                pn = pb + 8'(i);
                exp_q.push_back({1'b1, 8'hB0 | {5'd0, pn[2:0]}});
                exp_q.push_back({1'b1, {4'h0, cb[3:0]}});
                exp_q.push_back({1'b1, {4'h1, cb[7:4]}});
                for (int j = 0; j < w; j++) begin
                    exp_q.push_back({1'b0, m_dat});
                    m_dat++;
                end
            end
        end else begin
            if (!(m_cv && m_cb == cb && m_ce == ce)) begin
                exp_q.push_back({1'b1, 8'h21});
                exp_q.push_back({1'b1, cb});
                exp_q.push_back({1'b1, ce});
                m_cv = 1; m_cb = cb; m_ce = ce;
            end
            if (!(m_pv && m_pb == pb && m_pe == pe)) begin
                exp_q.push_back({1'b1, 8'h22});
                exp_q.push_back({1'b1, pb});
                exp_q.push_back({1'b1, pe});
                m_pv = 1; m_pb = pb; m_pe = pe;
            end
            for (int j = 0; j < int'(w) * int'(p); j++) begin
                exp_q.push_back({1'b0, m_dat});
                m_dat++;
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(got_q.size() == exp_q.size(), {tag, " stream length"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], tag, int'(got_q[i]), int'(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic run_req(input logic [7:0] x, w, fp, p, co, po, input bit msel, input bit ponly,
                           input string tag);
        int d0, t;
        d0 = done_cnt;
        @(negedge clk);
        req_x = x; req_width = w; req_page = fp; req_pages = p;
        col_off = co; page_off = po; mode_page = msel; page_only = ponly;
        req_valid = 1'b1;
        model(x, w, fp, p, co, po, msel | ponly);
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done_cnt == d0 + 1, "R9 done pulse count", done_cnt - d0, 1);
        compare(tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // reset state
        chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
        chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(pix_ready == 1'b0, "R12 reset pix_ready", pix_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: first horizontal request emits both ranges
        run_req(8'd4, 8'd3, 8'd0, 8'd2, 8'd0, 8'd1, 1'b0, 1'b0, "R5 R2 R3 first after reset");
        // R4: identical request skips both
        run_req(8'd4, 8'd3, 8'd0, 8'd2, 8'd0, 8'd1, 1'b0, 1'b0, "R4 repeat skips ranges");
        // R11: offsets wrap
        run_req(8'd5, 8'd2, 8'd3, 8'd2, 8'hFE, 8'hFF, 1'b0, 1'b0, "R11 horizontal offset wrap");
        run_req(8'h13, 8'd2, 8'd6, 8'd3, 8'hF0, 8'd4, 1'b1, 1'b0, "R11 R6 page offset wrap");

        // R1: request raised while busy is ignored
        begin
            int d0;
            d0 = done_cnt;
            @(negedge clk);
            req_x = 8'd0; req_width = 8'd8; req_page = 8'd0; req_pages = 8'd2;
            col_off = 8'd0; page_off = 8'd0; mode_page = 1'b0; page_only = 1'b0;
            req_valid = 1'b1;
            model(8'd0, 8'd8, 8'd0, 8'd2, 8'd0, 8'd0, 1'b0);
            @(negedge clk);
            req_x = 8'd40; req_width = 8'd1; req_pages = 8'd1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            while (done_cnt == d0) @(negedge clk);
            repeat (8) @(negedge clk);
            chk(done_cnt == d0 + 1, "R1 busy request ignored (done count)", done_cnt - d0, 1);
            compare("R1 busy request ignored (stream)");
        end

        // near-exhaustive sweep: style x width x pages x x-start, each twice
        for (int m = 0; m < 3; m++)
            for (int w = 1; w <= 4; w++)
                for (int p = 1; p <= 3; p++)
                    for (int xi = 0; xi < 2; xi++)
                        for (int rep = 0; rep < 2; rep++) begin
                            logic [7:0] xv;
                            xv = (xi == 0) ? 8'd0 : 8'd9;
                            if (m == 0)
                                run_req(xv, 8'(w), 8'd1, 8'(p), 8'd2, 8'd0, 1'b0, 1'b0,
                                        "R2 R3 R4 R7 R10 R12 horizontal sweep");
                            else if (m == 1)
                                run_req(xv, 8'(w), 8'd1, 8'(p), 8'd2, 8'd0, 1'b1, 1'b0,
                                        "R6 R7 R10 R12 page sweep");
                            else
                                run_req(xv, 8'(w), 8'd1, 8'(p), 8'd2, 8'd0, 1'b0, 1'b1,
                                        "R8 forced page sweep");
                        end

        // R8: page-style runs left the range cache intact
        run_req(8'd9, 8'd4, 8'd1, 8'd3, 8'd2, 8'd0, 1'b0, 1'b0, "R8 cache kept across page style");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule